// File: doc/BRIEF.md
# Retired-Instruction Counter Register Unit

This block keeps the retired-instruction count of a small processor hart and exposes it through a register read/write port. A single 64-bit count register sits behind every counter address the block decodes. The machine-level cycle and instret slots alias it, and so do their user-level read views. Each cycle in which the core reports a retirement adds one to the count. A software write through a machine-level address overrides that increment.

The register width is a parameter, 64 or 32. At 32 bits the count is reached as two halves: a low slot and a high slot, each written on its own. The block also decodes the performance-monitor counter slots 3 to 31, their event selectors and the count-inhibit register. These are fixed zero. Reads are combinational from the current register value, and writes land on the next clock edge.

An address outside the decoded set reads as zero and raises a miss flag, so that neighbouring register logic can claim it.

Top module: `mcnt_csr_unit`

## Requirements
- R1: After a clock edge with `rst_n` low, the count is zero.
- R2: On each clock edge with `retire_i` high and no counter write, the count rises by one. It carries from bit 31 into bit 32 and wraps from all-ones to zero. With `retire_i` low and no write, the count holds.
- R3: Reads of 0xB00, 0xB02, 0xC00 and 0xC02 all return the same count, combinationally. At 64-bit width this is the whole count; at 32-bit width it is bits 31:0.
- R4: With `csr_we_i` high at 0xB00 or 0xB02, the next edge loads the write data. At 64-bit width it replaces the whole count. At 32-bit width it replaces bits 31:0 and bits 63:32 keep their value.
- R5: At 32-bit width only, 0xB80, 0xB82, 0xC80 and 0xC82 read bits 63:32. A write at 0xB80 or 0xB82 replaces bits 63:32 and leaves bits 31:0 unchanged.
- R6: When a counter write and `retire_i` meet on the same edge, the written value is stored and the increment is lost.
- R7: The following addresses read zero, do not set the miss flag, and ignore writes: 0xB03–0xB1F, 0xC03–0xC1F and 0x323–0x33F. At 32-bit width, 0xB83–0xB9F and 0xC83–0xC9F behave the same way.
- R8: Address 0x320 reads zero and does not set the miss flag. Writing any value to it leaves counting unchanged.
- R9: Any other address reads zero with `csr_miss_o` high. This includes 0xB01, 0xC01, 0x321 and, at 64-bit width, the high-half slots. Every decoded address drives `csr_miss_o` low.
- R10: Writes to the user-level views 0xC00, 0xC02, 0xC80 and 0xC82 do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| retire_i | input | 1 | One instruction retired this cycle |
| csr_addr_i | input | 12 | Register address for both read and write |
| csr_we_i | input | 1 | Write strobe for the addressed register |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data of the addressed register |
| csr_miss_o | output | 1 | Address not decoded by this block |

## Verification
The bench builds two copies side by side, one with XLEN=64 and one with XLEN=32, and drives both with the same address, write and retire stream. The 32-bit copy brings the half-word writes within reach: the write that keeps the other half, and the carry from bit 31 into bit 32 after the low half is loaded with all ones. The 64-bit copy shows that the same high-half addresses become misses and that their writes change nothing. Both copies show the full wrap from all-ones to zero.

// File: rtl/mcnt_pkg.sv
// Package: shared address constants and decode types of the counter unit.
// Assumes a 12-bit register address split into a 7-bit page and a 5-bit slot.
package mcnt_pkg;

    localparam int ADDR_W = 12;
    localparam int IDX_W  = 5;
    localparam int PAGE_W = ADDR_W - IDX_W;

    // Pages of 32 slots each
    localparam logic [PAGE_W-1:0] PG_M_LO = 7'h58;  // 0xB00
    localparam logic [PAGE_W-1:0] PG_M_HI = 7'h5C;  // 0xB80
    localparam logic [PAGE_W-1:0] PG_U_LO = 7'h60;  // 0xC00
    localparam logic [PAGE_W-1:0] PG_U_HI = 7'h64;  // 0xC80
    localparam logic [PAGE_W-1:0] PG_EVT  = 7'h19;  // 0x320

    // Slots inside a page
    localparam logic [IDX_W-1:0] IDX_CYC       = 5'd0;
    localparam logic [IDX_W-1:0] IDX_RET       = 5'd2;
    localparam logic [IDX_W-1:0] IDX_HPM_FIRST = 5'd3;

    localparam logic [ADDR_W-1:0] ADR_INHIBIT = 12'h320;

    // Read source chosen by the decoder
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_ZERO = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/mcnt_decode.sv
// Module: address decoder of the counter unit.
// Sorts an address into count-low, count-high, fixed-zero or not-decoded.
// Write strobes are produced only for the machine-level count slots.
// Assumes XLEN is CNT_W or CNT_W/2; the high pages exist only in the second case.
module mcnt_decode
    import mcnt_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int CNT_W = 64
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    output rd_sel_e           sel_o,
    output logic              wr_lo_o,
    output logic              wr_hi_o
);

    localparam bit HAS_HI = (XLEN < CNT_W);

    logic [PAGE_W-1:0] page;
    logic [IDX_W-1:0]  idx;
    logic              idx_ctr;
    logic              idx_hpm;
    logic              pg_mlo;
    logic              pg_lo;
    logic              pg_mhi;
    logic              pg_hi;
    logic              pg_evt;

    assign page    = addr_i[ADDR_W-1:IDX_W];
    assign idx     = addr_i[IDX_W-1:0];
    assign idx_ctr = (idx == IDX_CYC) || (idx == IDX_RET);
    assign idx_hpm = (idx >= IDX_HPM_FIRST);
    assign pg_mlo  = (page == PG_M_LO);
    assign pg_lo   = pg_mlo || (page == PG_U_LO);
    assign pg_mhi  = HAS_HI && (page == PG_M_HI);
    assign pg_hi   = pg_mhi || (HAS_HI && (page == PG_U_HI));
    assign pg_evt  = (page == PG_EVT);

    // Purpose: pick the read source for the current address.
    always_comb begin
        if (pg_lo && idx_ctr) begin
            sel_o = SEL_LO;
        end else if (pg_hi && idx_ctr) begin
            sel_o = SEL_HI;
        end else if ((pg_lo || pg_hi || pg_evt) && idx_hpm) begin
            sel_o = SEL_ZERO;
        end else if (addr_i == ADR_INHIBIT) begin
            sel_o = SEL_ZERO;
        end else begin
            sel_o = SEL_NONE;
        end
    end

    // Only machine-level count slots accept writes.
    assign wr_lo_o = we_i && pg_mlo && idx_ctr;
    assign wr_hi_o = we_i && pg_mhi && idx_ctr;

endmodule

// File: rtl/mcnt_store.sv
// Module: the shared count register.
// A write replaces the whole count, or one half of it when XLEN is half of
// CNT_W. A write on an edge suppresses that edge's retire increment.
// Assumes at most one of wr_lo_i and wr_hi_i is high.
module mcnt_store #(
    parameter int XLEN  = 64,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [XLEN-1:0]  wdata_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             wr_any;

    assign wr_any = wr_lo_i || wr_hi_i;

    generate
        if (XLEN >= CNT_W) begin : g_full
            // Purpose: next count for the full-width variant.
            always_comb begin
                cnt_d = cnt_q;
                if (wr_any) begin
                    cnt_d = wdata_i[CNT_W-1:0];
                end else if (inc_i) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        end else begin : g_split
            // Purpose: next count for the half-width variant, merging one half.
            always_comb begin
                cnt_d = cnt_q;
                if (wr_any) begin
                    if (wr_lo_i) begin
                        cnt_d[XLEN-1:0] = wdata_i;
                    end
                    if (wr_hi_i) begin
                        cnt_d[CNT_W-1:XLEN] = wdata_i[CNT_W-XLEN-1:0];
                    end
                end else if (inc_i) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        end
    endgenerate

    // Purpose: hold the count, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/mcnt_rdmux.sv
// Module: read multiplexer of the counter unit.
// Returns the low or high word of the count, zero, or zero with a miss flag.
// Purely combinational; assumes the high word is never selected when XLEN
// equals CNT_W.
module mcnt_rdmux
    import mcnt_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int CNT_W = 64
) (
    input  rd_sel_e          sel_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [XLEN-1:0]  rdata_o,
    output logic             miss_o
);

    logic [XLEN-1:0] lo_word;
    logic [XLEN-1:0] hi_word;

    assign lo_word = cnt_i[XLEN-1:0];

    generate
        if (XLEN < CNT_W) begin : g_hi
            assign hi_word = cnt_i[CNT_W-1:XLEN];
        end else begin : g_nohi
            assign hi_word = '0;
        end
    endgenerate

    // Purpose: drive read data and miss flag from the selected source.
    always_comb begin
        rdata_o = '0;
        miss_o  = 1'b0;
        case (sel_i)
            SEL_LO:   rdata_o = lo_word;
            SEL_HI:   rdata_o = hi_word;
            SEL_ZERO: rdata_o = '0;
            default:  miss_o  = 1'b1;
        endcase
    end

endmodule

// File: rtl/mcnt_csr_unit.sv
// Module: top of the retired-instruction counter register unit.
// Ties the decoder, the shared count register and the read multiplexer together.
// Assumes XLEN is 64 or 32 with a 64-bit count, and synchronous active-low reset.
module mcnt_csr_unit
    import mcnt_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic              csr_we_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              csr_miss_o
);

    rd_sel_e          rd_sel;
    logic             wr_lo;
    logic             wr_hi;
    logic [CNT_W-1:0] cnt_q;

    mcnt_decode #(.XLEN(XLEN), .CNT_W(CNT_W)) u_decode (
        .addr_i  (csr_addr_i),
        .we_i    (csr_we_i),
        .sel_o   (rd_sel),
        .wr_lo_o (wr_lo),
        .wr_hi_o (wr_hi)
    );

    mcnt_store #(.XLEN(XLEN), .CNT_W(CNT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (retire_i),
        .wr_lo_i (wr_lo),
        .wr_hi_i (wr_hi),
        .wdata_i (csr_wdata_i),
        .cnt_o   (cnt_q)
    );

    mcnt_rdmux #(.XLEN(XLEN), .CNT_W(CNT_W)) u_rdmux (
        .sel_i   (rd_sel),
        .cnt_i   (cnt_q),
        .rdata_o (csr_rdata_o),
        .miss_o  (csr_miss_o)
    );

endmodule

// File: rtl/mcnt_csr_chk.sv
// Module: assertion checker for the counter unit, bound into every instance.
// Observes ports plus the count register and the decoded write strobes.
module mcnt_csr_chk #(
    parameter int XLEN  = 64,
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             retire_i,
    input logic [11:0]      csr_addr_i,
    input logic [XLEN-1:0]  csr_wdata_i,
    input logic [XLEN-1:0]  csr_rdata_o,
    input logic             csr_miss_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic             wr_lo,
    input logic             wr_hi
);

    // Purpose: remember that the previous edge saw reset low.
    logic prev_rst_low = 1'b0;
    always_ff @(posedge clk) begin
        prev_rst_low <= !rst_n;
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        prev_rst_low |-> (cnt_q == '0));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && !wr_lo && !wr_hi) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire_i && !wr_lo && !wr_hi) |=> $stable(cnt_q));

    p_alias_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr_i == 12'hB00 || csr_addr_i == 12'hB02 ||
         csr_addr_i == 12'hC00 || csr_addr_i == 12'hC02)
        |-> (csr_rdata_o == cnt_q[XLEN-1:0] && !csr_miss_o));

    generate
        if (XLEN >= CNT_W) begin : g_full
            p_write_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
                wr_lo |=> (cnt_q == $past(csr_wdata_i)));
            p_write_beats_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_lo && retire_i) |=> (cnt_q == $past(csr_wdata_i)));
        end else begin : g_split
            p_write_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
                wr_lo |=> (cnt_q[XLEN-1:0] == $past(csr_wdata_i) &&
                           cnt_q[CNT_W-1:XLEN] == $past(cnt_q[CNT_W-1:XLEN])));
            p_write_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hi |=> (cnt_q[CNT_W-1:XLEN] == $past(csr_wdata_i) &&
                           cnt_q[XLEN-1:0] == $past(cnt_q[XLEN-1:0])));
            p_write_beats_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
                ((wr_lo || wr_hi) && retire_i) |=> (cnt_q != $past(cnt_q) + 1'b1 ||
                 cnt_q == $past(cnt_q) + 1'b1 && $past(csr_wdata_i) == cnt_q[XLEN-1:0] ||
                 cnt_q == $past(cnt_q) + 1'b1 && $past(csr_wdata_i) == cnt_q[CNT_W-1:XLEN]));
        end
    endgenerate

    p_monitor_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((csr_addr_i >= 12'hB03 && csr_addr_i <= 12'hB1F) ||
         (csr_addr_i >= 12'h323 && csr_addr_i <= 12'h33F))
        |-> (csr_rdata_o == '0 && !csr_miss_o));

    p_inhibit_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr_i == 12'h320) |-> (csr_rdata_o == '0 && !csr_miss_o));

    p_miss_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        csr_miss_o |-> (csr_rdata_o == '0));

endmodule

bind mcnt_csr_unit mcnt_csr_chk #(.XLEN(XLEN), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .retire_i    (retire_i),
    .csr_addr_i  (csr_addr_i),
    .csr_wdata_i (csr_wdata_i),
    .csr_rdata_o (csr_rdata_o),
    .csr_miss_o  (csr_miss_o),
    .cnt_q       (cnt_q),
    .wr_lo       (wr_lo),
    .wr_hi       (wr_hi)
);

// File: tb/tb_mcnt_csr_unit.sv
// Bench: a 64-bit and a 32-bit copy, same stimulus, each with a behavioural model.
module tb_mcnt_csr_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire = 1'b0;
    logic [11:0] addr = 12'h000;
    logic        we = 1'b0;
    logic [63:0] wdata = '0;

    logic [63:0] rdata64;
    logic        miss64;
    logic [31:0] rdata32;
    logic        miss32;

    logic [63:0] m64 = '0;
    logic [63:0] m32 = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mcnt_csr_unit #(.XLEN(64), .CNT_W(64)) dut (
        .clk(clk), .rst_n(rst_n), .retire_i(retire), .csr_addr_i(addr),
        .csr_we_i(we), .csr_wdata_i(wdata), .csr_rdata_o(rdata64), .csr_miss_o(miss64)
    );

    mcnt_csr_unit #(.XLEN(32), .CNT_W(64)) dut32 (
        .clk(clk), .rst_n(rst_n), .retire_i(retire), .csr_addr_i(addr),
        .csr_we_i(we), .csr_wdata_i(wdata[31:0]), .csr_rdata_o(rdata32), .csr_miss_o(miss32)
    );

    function automatic bit is_cnt_lo(logic [11:0] a);
        return a == 12'hB00 || a == 12'hB02 || a == 12'hC00 || a == 12'hC02;
    endfunction

    function automatic bit is_cnt_hi(logic [11:0] a);
        return a == 12'hB80 || a == 12'hB82 || a == 12'hC80 || a == 12'hC82;
    endfunction

    // Expected read data and miss flag for a given width and model count.
    function automatic void model_read(int xl, logic [63:0] c, logic [11:0] a,
                                       output logic [63:0] rd, output bit miss);
        rd = '0;
        miss = 1'b0;
        if (is_cnt_lo(a)) begin
            rd = (xl == 32) ? {32'h0, c[31:0]} : c;
        end else if (xl == 32 && is_cnt_hi(a)) begin
            rd = {32'h0, c[63:32]};
        end else if ((a >= 12'hB03 && a <= 12'hB1F) || (a >= 12'hC03 && a <= 12'hC1F) ||
                     (a >= 12'h323 && a <= 12'h33F) || a == 12'h320) begin
            rd = '0;
        end else if (xl == 32 && ((a >= 12'hB83 && a <= 12'hB9F) ||
                                  (a >= 12'hC83 && a <= 12'hC9F))) begin
            rd = '0;
        end else begin
            miss = 1'b1;
        end
    endfunction

    // Next count of the model for one clock edge.
    function automatic logic [63:0] model_next(int xl, logic [63:0] c, logic [11:0] a,
                                               logic w, logic [63:0] d, logic r);
        logic [63:0] n;
        n = c;
        if (w && (a == 12'hB00 || a == 12'hB02)) begin
            if (xl == 32) n[31:0] = d[31:0];
            else n = d;
        end else if (w && xl == 32 && (a == 12'hB80 || a == 12'hB82)) begin
            n[63:32] = d[31:0];
        end else if (r) begin
            n = c + 64'd1;
        end
        return n;
    endfunction

    // Purpose: advance both reference models on each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m64 = '0;
            m32 = '0;
        end else begin
            m64 = model_next(64, m64, addr, we, wdata, retire);
            m32 = model_next(32, m32, addr, we, wdata, retire);
        end
    end

    task automatic compare(string tag);
        logic [63:0] e64;
        logic [63:0] e32;
        bit          em64;
        bit          em32;
        model_read(64, m64, addr, e64, em64);
        model_read(32, m32, addr, e32, em32);
        checks += 4;
        if (rdata64 !== e64) begin
            fails++;
            $display("FAIL %s w64 rdata addr=%h actual=%h expected=%h", tag, addr, rdata64, e64);
        end
        if (miss64 !== em64) begin
            fails++;
            $display("FAIL %s w64 miss addr=%h actual=%b expected=%b", tag, addr, miss64, em64);
        end
        if (rdata32 !== e32[31:0]) begin
            fails++;
            $display("FAIL %s w32 rdata addr=%h actual=%h expected=%h", tag, addr, rdata32, e32[31:0]);
        end
        if (miss32 !== em32) begin
            fails++;
            $display("FAIL %s w32 miss addr=%h actual=%b expected=%b", tag, addr, miss32, em32);
        end
    endtask

    // One cycle: apply inputs after a falling edge, then compare mid-cycle.
    task automatic step(string tag, logic [11:0] a, logic w, logic [63:0] d, logic r);
        @(negedge clk);
        addr   = a;
        we     = w;
        wdata  = d;
        retire = r;
        #1;
        compare(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d cycles expected=completion", WDOG_CYCLES);
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: count is zero after reset
        step("R1", 12'hB00, 1'b0, '0, 1'b0);
        // R2: increments on retire, holds without
        for (int i = 0; i < 5; i++) step("R2", 12'hB02, 1'b0, '0, 1'b1);
        step("R2", 12'hB02, 1'b0, '0, 1'b0);
        step("R2", 12'hB02, 1'b0, '0, 1'b0);
        // R3: alias reads
        step("R3", 12'hC00, 1'b0, '0, 1'b0);
        step("R3", 12'hC02, 1'b0, '0, 1'b0);
        step("R3", 12'hB00, 1'b0, '0, 1'b0);
        // R4: full or low-half write
        step("R4", 12'hB00, 1'b1, 64'h1234_5678_9ABC_DEF0, 1'b0);
        step("R4", 12'hB00, 1'b0, '0, 1'b0);
        step("R4", 12'hB80, 1'b0, '0, 1'b0);
        // R5: high-half reads and write
        step("R5", 12'hC80, 1'b0, '0, 1'b0);
        step("R5", 12'hC82, 1'b0, '0, 1'b0);
        step("R5", 12'hB82, 1'b1, 64'hAAAA_5555_0000_0001, 1'b0);
        step("R5", 12'hB80, 1'b0, '0, 1'b0);
        step("R5", 12'hB02, 1'b0, '0, 1'b0);
        // R6: write wins over retire
        step("R6", 12'hB02, 1'b1, 64'h10, 1'b1);
        step("R6", 12'hB02, 1'b0, '0, 1'b0);
        step("R6", 12'hB80, 1'b1, 64'h7, 1'b1);
        step("R6", 12'hB80, 1'b0, '0, 1'b0);
        step("R6", 12'hB00, 1'b0, '0, 1'b0);
        // R2: carry across bit 31 and wrap at all-ones
        step("R2", 12'hB00, 1'b1, 64'h0000_0000_FFFF_FFFF, 1'b0);
        step("R2", 12'hB00, 1'b0, '0, 1'b1);
        step("R2", 12'hB80, 1'b0, '0, 1'b0);
        step("R2", 12'hB00, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        step("R2", 12'hB80, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        step("R2", 12'hB00, 1'b0, '0, 1'b1);
        step("R2", 12'hB80, 1'b0, '0, 1'b0);
        step("R2", 12'hB00, 1'b0, '0, 1'b0);
        // R7: monitor counters and selectors read zero, writes ignored
        step("R7", 12'hB05, 1'b1, 64'hDEAD_BEEF, 1'b1);
        step("R7", 12'hC1F, 1'b1, 64'h1111, 1'b0);
        step("R7", 12'h33F, 1'b1, 64'h2222, 1'b1);
        step("R7", 12'h323, 1'b0, '0, 1'b0);
        step("R7", 12'hB9F, 1'b1, 64'h3333, 1'b0);
        step("R7", 12'hC83, 1'b1, 64'h4444, 1'b0);
        step("R7", 12'hB05, 1'b0, '0, 1'b0);
        step("R7", 12'hB02, 1'b0, '0, 1'b0);
        step("R7", 12'hB82, 1'b0, '0, 1'b0);
        // R8: inhibit reads zero and does not stop counting
        step("R8", 12'h320, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        step("R8", 12'h320, 1'b0, '0, 1'b1);
        step("R8", 12'h320, 1'b0, '0, 1'b1);
        step("R8", 12'hB00, 1'b0, '0, 1'b0);
        // R9: undecoded addresses miss and read zero
        step("R9", 12'hB01, 1'b0, '0, 1'b0);
        step("R9", 12'hC01, 1'b0, '0, 1'b0);
        step("R9", 12'h321, 1'b0, '0, 1'b0);
        step("R9", 12'h000, 1'b1, 64'h99, 1'b0);
        step("R9", 12'hFFF, 1'b0, '0, 1'b0);
        step("R9", 12'hB81, 1'b0, '0, 1'b0);
        step("R9", 12'hB00, 1'b0, '0, 1'b0);
        // R10: user-level views ignore writes
        step("R10", 12'hC00, 1'b1, 64'h55, 1'b0);
        step("R10", 12'hC82, 1'b1, 64'h66, 1'b0);
        step("R10", 12'hB00, 1'b0, '0, 1'b0);
        step("R10", 12'hB80, 1'b0, '0, 1'b0);
        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        retire = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", 12'hB00, 1'b0, '0, 1'b0);
        step("R1", 12'hB80, 1'b0, '0, 1'b0);

        finish_run();
    end

endmodule